// File: doc/BRIEF.md
# Single-Wire Pulse-Width Bit-Slot Slave

This block is the slave end of a one-wire, open-drain link. The idle line is pulled high. The master opens every bit slot by pulling the line low, and the length of that low pulse carries the bit value. A short low is a 1 and a long low is a 0. A low that lasts far longer than a data bit is a sync pulse, which resets the slave's bit state. The slave has no transmit clock of its own. It answers inside the master's slot: to send a 0 it stretches the low pulse, and to send a 1 it leaves the line alone.

Timing comes from a tick at four times the bit rate. The block divides the tick down from the system clock, and the divider runs only while a slot is in progress. It starts on the falling edge of the line and stops after the line has stayed high for a full slot. A 3-bit Gray-coded slot counter counts ticks from the slot start. Three decodes of that counter are used: the point where the received bit is sampled, the window in which the slave drives its reply, and the point where a sync pulse is recognised. Bits come out one at a time. Assembly into words is left to the logic above.

Top module: `pwm_slot_slave`

## Requirements
- R1: While reset is held, and in the first cycle after it is released with the line high, `drv_low`, `busy`, `rx_bit`, `rx_valid` and `sync_pulse` are all 0.
- R2: A high-to-low transition of `line_in` sets `busy` in the next cycle and starts a slot. Tick k of the slot then falls on the clock edge k·TICK_DIV cycles after the edge that saw the transition. The slot position is held in Gray code and changes by at most one bit per cycle, except when a slot restarts.
- R3: The line is sampled at the 2nd tick. High gives bit value 1 and low gives bit value 0. With the defaults, a low of 1 or 2 ticks is read as 1, and a low of 3 or 4 ticks is read as 0.
- R4: `rx_valid` pulses for exactly one cycle, in the cycle after the 4th tick. It pulses only if the line is high at that tick, and at the same time `rx_bit` takes the sampled value. `rx_bit` changes only in a cycle where `rx_valid` or `sync_pulse` is 1.
- R5: If the line is still low at the 6th tick, `sync_pulse` is 1 for exactly one cycle, in the cycle after that tick. This happens at most once per slot, however long the low lasts, and a slot that produces a sync produces no `rx_valid`. A low that ends after the 4th tick but before the 6th produces neither output.
- R6: A sync pulse clears `rx_bit` to 0 in the same cycle as `sync_pulse`.
- R7: If `tx_en`=1 and `tx_bit`=0 at the cycle of the falling edge, `drv_low` is 1 from the cycle after the edge through the 3rd tick, which is 3·TICK_DIV cycles in all. Otherwise `drv_low` stays 0 for the whole slot. The slave's own drive is read back as a received 0.
- R8: `busy` drops in the cycle after the tick at which the line has been high on 4 consecutive ticks. For a master 1 with no reply, this is the cycle after the 4th tick.
- R9: A falling edge while `busy` is 1 restarts the slot from position 0. The earlier slot then produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, TICK_DIV cycles per slot tick |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Sensed level of the shared wire, synchronous to clk |
| tx_en | input | 1 | Slave replies in the next slot |
| tx_bit | input | 1 | Reply bit value, taken at the slot start |
| drv_low | output | 1 | Open-drain pull-down enable for the wire |
| busy | output | 1 | Tick gate is on, a slot is in progress |
| rx_bit | output | 1 | Last received bit (0 after sync) |
| rx_valid | output | 1 | One-cycle strobe: rx_bit holds a new bit |
| sync_pulse | output | 1 | One-cycle strobe: sync pulse recognised |

## Verification
A slot counter that is one position off moves every decode with it. `rx_valid` or `sync_pulse` then arrives TICK_DIV cycles early or late, low pulses of 2 or 4 ticks decode to the wrong value, and the reply drive grows or shrinks by one tick. All of this shows within the slot in which the fault occurs. A gate that fails to stop shows as `busy` still high after the fourth high tick. A gate that fails to restart on a mid-slot edge produces a spurious bit, or a bit at the wrong time, within that same slot. A lost sync clear leaves a 1 on `rx_bit` in the cycle of the strobe.

// File: rtl/pwm_slot_pkg.sv
package pwm_slot_pkg;

  localparam int SLOT_W = 3;
  typedef logic [SLOT_W-1:0] slot_t;

  // Position values reached after the k-th tick of a slot is k.
  // An event "at tick k" is decoded as a tick while the position is k-1.
  localparam slot_t POS_SAMPLE = slot_t'(1);  // 2nd tick
  localparam slot_t POS_CHECK  = slot_t'(3);  // 4th tick
  localparam slot_t POS_SYNC   = slot_t'(5);  // 6th tick
  localparam slot_t POS_DRVEND = slot_t'(3);  // drive released once 3rd tick passed
  localparam slot_t POS_LAST   = slot_t'((1 << SLOT_W) - 1);

  localparam int IDLE_TICKS = 4;

  function automatic slot_t bin2gray(input slot_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic slot_t gray2bin(input slot_t g);
    slot_t b;
    b[SLOT_W-1] = g[SLOT_W-1];
    for (int i = SLOT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(TICK_DIV - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  div_q <= '0;
    else if (restart || !run)    div_q <= '0;
    else if (div_q == DIV_LAST)  div_q <= '0;
    else                         div_q <= div_q + 1'b1;
  end

  assign tick = run && !restart && (div_q == DIV_LAST);
endmodule

// File: rtl/pwm_gate.sv
module pwm_gate #(
  parameter int IDLE_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  input  logic fall,
  input  logic tick,
  output logic run
);
  localparam int HW = $clog2(IDLE_TICKS + 1);
  localparam logic [HW-1:0] HI_LAST = HW'(IDLE_TICKS - 1);

  logic          run_q;
  logic [HW-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      hi_q  <= '0;
    end else if (fall) begin
      run_q <= 1'b1;
      hi_q  <= '0;
    end else if (run_q && tick) begin
      if (!line) begin
        hi_q <= '0;
      end else if (hi_q == HI_LAST) begin
        run_q <= 1'b0;
        hi_q  <= '0;
      end else begin
        hi_q <= hi_q + 1'b1;
      end
    end
  end

  assign run = run_q;
endmodule

// File: rtl/pwm_slot_seq.sv
module pwm_slot_seq
  import pwm_slot_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  restart,
  input  logic  tick,
  output slot_t slot_gray,
  output logic  ev_sample,
  output logic  ev_check,
  output logic  ev_sync_pt
);
  slot_t g_q;
  slot_t pos;

  assign pos = gray2bin(g_q);

  always_ff @(posedge clk) begin
    if (!rst_n)                          g_q <= '0;
    else if (restart)                    g_q <= '0;
    else if (tick && (pos != POS_LAST))  g_q <= bin2gray(pos + slot_t'(1));
  end

  assign slot_gray  = g_q;
  assign ev_sample  = tick && (pos == POS_SAMPLE);
  assign ev_check   = tick && (pos == POS_CHECK);
  assign ev_sync_pt = tick && (pos == POS_SYNC);
endmodule

// File: rtl/pwm_slot_slave.sv
module pwm_slot_slave
  import pwm_slot_pkg::*;
#(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic tx_en,
  input  logic tx_bit,
  output logic drv_low,
  output logic busy,
  output logic rx_bit,
  output logic rx_valid,
  output logic sync_pulse
);
  logic  line_q;
  logic  ev_fall;
  logic  run;
  logic  tick;
  slot_t slot_gray;
  logic  ev_sample, ev_check, ev_sync_pt;
  logic  drv_win;
  logic  tx_zero_q;
  logic  samp_q;
  logic  rx_bit_q, rx_valid_q, sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) line_q <= 1'b1;
    else        line_q <= line_in;
  end

  assign ev_fall = line_q && !line_in;

  pwm_gate #(.IDLE_TICKS(IDLE_TICKS)) u_gate (
    .clk(clk), .rst_n(rst_n), .line(line_in), .fall(ev_fall), .tick(tick), .run(run)
  );

  pwm_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(ev_fall), .tick(tick)
  );

  pwm_slot_seq u_seq (
    .clk(clk), .rst_n(rst_n), .restart(ev_fall), .tick(tick),
    .slot_gray(slot_gray), .ev_sample(ev_sample), .ev_check(ev_check),
    .ev_sync_pt(ev_sync_pt)
  );

  // Window covers positions 0..2; the Gray code keeps the decode glitch-free.
  assign drv_win = (gray2bin(slot_gray) < POS_DRVEND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_zero_q  <= 1'b0;
      samp_q     <= 1'b0;
      rx_bit_q   <= 1'b0;
      rx_valid_q <= 1'b0;
      sync_q     <= 1'b0;
    end else begin
      rx_valid_q <= 1'b0;
      sync_q     <= 1'b0;
      if (ev_fall) tx_zero_q <= tx_en && !tx_bit;
      if (ev_sample) samp_q <= line_in;
      if (ev_check && line_in) begin
        rx_valid_q <= 1'b1;
        rx_bit_q   <= samp_q;
      end
      if (ev_sync_pt && !line_in) begin
        sync_q   <= 1'b1;
        samp_q   <= 1'b0;
        rx_bit_q <= 1'b0;
      end
    end
  end

  assign drv_low    = run && tx_zero_q && drv_win;
  assign busy       = run;
  assign rx_bit     = rx_bit_q;
  assign rx_valid   = rx_valid_q;
  assign sync_pulse = sync_q;
endmodule

// File: rtl/pwm_slot_slave_chk.sv
module pwm_slot_slave_chk
  import pwm_slot_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  ev_fall,
  input slot_t slot_gray,
  input logic  busy,
  input logic  drv_low,
  input logic  rx_bit,
  input logic  rx_valid,
  input logic  sync_pulse
);
  AST_FALL_STARTS: assert property (@(posedge clk) disable iff (!rst_n) ev_fall |=> busy); // R2
  AST_GRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n) !$past(ev_fall) |-> ($countones(slot_gray ^ $past(slot_gray)) <= 1)); // R2
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |=> !rx_valid); // R4
  AST_RX_CHANGE_STROBED: assert property (@(posedge clk) disable iff (!rst_n) !$stable(rx_bit) |-> (rx_valid || sync_pulse)); // R4
  AST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) sync_pulse |=> !sync_pulse); // R5
  AST_SYNC_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n) !(sync_pulse && rx_valid)); // R5
  AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) sync_pulse |-> !rx_bit); // R6
  AST_DRV_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n) (drv_low && !$past(drv_low)) |-> $past(ev_fall)); // R7
endmodule

bind pwm_slot_slave pwm_slot_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_fall(ev_fall), .slot_gray(slot_gray), .busy(busy),
  .drv_low(drv_low), .rx_bit(rx_bit), .rx_valid(rx_valid), .sync_pulse(sync_pulse)
);

// File: tb/tb_pwm_slot_slave.sv
module tb_pwm_slot_slave;
  localparam int CLK_PERIOD = 10;
  localparam int TD = 4;
  localparam int WD_CYCLES = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_low = 1'b0;
  logic tx_en = 1'b0, tx_bit = 1'b0;
  logic line_in, drv_low, busy, rx_bit, rx_valid, sync_pulse;

  assign line_in = ~(master_low | drv_low);

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_slot_slave #(.TICK_DIV(TD)) dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .tx_en(tx_en), .tx_bit(tx_bit),
    .drv_low(drv_low), .busy(busy), .rx_bit(rx_bit), .rx_valid(rx_valid),
    .sync_pulse(sync_pulse)
  );

  typedef struct packed {
    logic [7:0] len;
    logic       txe;
    logic       txb;
    logic [1:0] nval;
    logic       bv;
    logic [1:0] nsy;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{8'(TD),       1'b0, 1'b0, 2'd1, 1'b1, 2'd0},
    '{8'(3*TD),     1'b0, 1'b0, 2'd1, 1'b0, 2'd0},
    '{8'(2*TD),     1'b0, 1'b0, 2'd1, 1'b1, 2'd0},
    '{8'(2*TD+1),   1'b0, 1'b0, 2'd1, 1'b0, 2'd0},
    '{8'(4*TD),     1'b0, 1'b0, 2'd1, 1'b0, 2'd0},
    '{8'(4*TD+1),   1'b0, 1'b0, 2'd0, 1'b0, 2'd0},
    '{8'(6*TD),     1'b0, 1'b0, 2'd0, 1'b0, 2'd0},
    '{8'(6*TD+1),   1'b0, 1'b0, 2'd0, 1'b0, 2'd1},
    '{8'(10*TD),    1'b0, 1'b0, 2'd0, 1'b0, 2'd1},
    '{8'(TD),       1'b1, 1'b0, 2'd1, 1'b0, 2'd0},
    '{8'(TD),       1'b1, 1'b1, 2'd1, 1'b1, 2'd0},
    '{8'(1),        1'b0, 1'b0, 2'd1, 1'b1, 2'd0}
  };

  int checks = 0, failures = 0, cyc = 0, start = 0;
  int n_valid, n_sync, n_drv, last_bit, valid_rel, sync_rel, drv_first, drv_last, busy_off_rel;
  bit done = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_CYCLES && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rx_valid) begin
      n_valid++;
      last_bit = int'(rx_bit);
      valid_rel = cyc - start;
    end
    if (sync_pulse) begin
      n_sync++;
      sync_rel = cyc - start;
    end
    if (drv_low) begin
      n_drv++;
      if (drv_first < 0) drv_first = cyc - start;
      drv_last = cyc - start;
    end
    if (!busy && busy_off_rel < 0 && cyc >= start) busy_off_rel = cyc - start;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic begin_slot(input logic te, input logic tb);
    @(negedge clk);
    tx_en = te;
    tx_bit = tb;
    n_valid = 0; n_sync = 0; n_drv = 0; last_bit = -1;
    valid_rel = -1; sync_rel = -1; drv_first = -1; drv_last = -1; busy_off_rel = -1;
    start = cyc + 1;
    master_low = 1'b1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic run_slot(input int len, input logic te, input logic tb);
    begin_slot(te, tb);
    repeat (len) @(negedge clk);
    master_low = 1'b0;
    wait_idle();
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "drv_low in reset", int'(drv_low), 0);
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "rx_valid in reset", int'(rx_valid), 0);
    chk("R1", "sync_pulse in reset", int'(sync_pulse), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "rx_bit after reset", int'(rx_bit), 0);
    chk("R1", "busy after reset", int'(busy), 0);

    // Table of slots: R3 decode, R4 strobe, R5 sync, R7 reply
    for (int v = 0; v < NV; v++) begin
      run_slot(int'(VEC[v].len), VEC[v].txe, VEC[v].txb);
      chk("R4", $sformatf("vec%0d valid count", v), n_valid, int'(VEC[v].nval));
      if (VEC[v].nval != 0)
        chk("R3", $sformatf("vec%0d bit", v), last_bit, int'(VEC[v].bv));
      chk("R5", $sformatf("vec%0d sync count", v), n_sync, int'(VEC[v].nsy));
      chk("R7", $sformatf("vec%0d drive cycles", v), n_drv,
          (VEC[v].txe && !VEC[v].txb) ? 3*TD : 0);
    end

    // R2/R4/R8: timing of a plain 1 slot
    begin_slot(1'b0, 1'b0);
    @(negedge clk);
    chk("R2", "busy one cycle after fall", int'(busy), 1);
    repeat (TD - 1) @(negedge clk);
    master_low = 1'b0;
    wait_idle();
    chk("R4", "valid at tick 4", valid_rel, 4*TD);
    chk("R8", "busy drops after 4 high ticks", busy_off_rel, 4*TD);
    chk("R3", "rx_bit holds 1", int'(rx_bit), 1);

    // R5/R6: sync clears the held 1
    run_slot(6*TD + 1, 1'b0, 1'b0);
    chk("R5", "sync at tick 6", sync_rel, 6*TD);
    chk("R6", "rx_bit cleared by sync", int'(rx_bit), 0);
    chk("R5", "no valid in sync slot", n_valid, 0);

    // R7/R8: reply window edges
    run_slot(TD, 1'b1, 1'b0);
    chk("R7", "drive first cycle", drv_first, 0);
    chk("R7", "drive last cycle", drv_last, 3*TD - 1);
    chk("R8", "busy drops after reply", busy_off_rel, 7*TD);

    // R9: new fall mid-slot restarts the slot
    begin_slot(1'b0, 1'b0);
    repeat (TD) @(negedge clk);
    master_low = 1'b0;
    repeat (TD) @(negedge clk);
    master_low = 1'b1;
    repeat (3*TD) @(negedge clk);
    master_low = 1'b0;
    wait_idle();
    chk("R9", "single valid after restart", n_valid, 1);
    chk("R9", "restarted bit value", last_bit, 0);
    chk("R9", "valid timed from restart", valid_rel, 6*TD);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule